// File: doc/BRIEF.md
# Dual-clock FIFO with programmable level flags

This block is a first-in first-out buffer whose write port and read port run on separate, unrelated clocks. Words enter on rising `wclk` and leave on rising `rclk`; the read data appears on a three-state output bus. Four active-low flags report the fill level: full and almost-full are produced in the write clock domain, and empty and almost-empty in the read clock domain. The almost-full threshold (m) and the almost-empty threshold (n) are programmable.

Each threshold is wider than a byte, so it is kept as a low byte and a high part. The four parts are written one after another through the data input and read back one after another through the data output. A single shared pin has two roles. It is sampled while reset is held. If it is high during reset, it later works as a second write enable. If it is low during reset, it later works as the select line for threshold access. Writes need both write qualifiers, and reads need both read enables. For single-buffer use, `rd_en2` can be tied high.

Top module: `sfifo_pflag`

## Requirements
- R1: Words leave in the order they were accepted, across the two clocks. A word read on a rising `rclk` edge is on `dout` after that edge.
- R2: In second-enable mode, a word is written only when `wr_en1` and `wr_en2_load` are both high. A write cycle with `wr_en2_load` low stores nothing.
- R3: A word is read only when `rd_en1` and `rd_en2` are both high. A read cycle with `rd_en2` low removes nothing.
- R4: `full_n` goes low once 2^AW words are stored (1024 by default). Writes while it is low are dropped and no stored word is overwritten.
- R5: `empty_n` is low while no word is stored. Reads while it is low are dropped and `dout` keeps its last value.
- R6: `almost_full_n` is low when the stored level is at least 2^AW minus the almost-full threshold m.
- R7: `almost_empty_n` is low when the stored level is at most the almost-empty threshold n.
- R8: After reset both thresholds hold the value 7.
- R9: In load mode, a `wclk` edge with `wr_en1` high and `wr_en2_load` high writes `din` into the next threshold part. The parts are taken in a fixed cyclic order: n bits [7:0] from din[7:0], n bits [9:8] from din[1:0], m bits [7:0], then m bits [9:8]. No FIFO word is stored by such an edge.
- R10: In load mode, an `rclk` edge with both read enables high and `wr_en2_load` high puts the next threshold part on `dout`, in the same cyclic order and zero-extended. A high part reads back with every bit above [1:0] at zero. No FIFO word is consumed by such an edge.
- R11: The level of `wr_en2_load` while `rst` is high picks the mode: high gives second-enable mode, low gives load mode. In load mode, a FIFO write is `wr_en1` high with `wr_en2_load` low.
- R12: `dout` is high-impedance whenever `out_en` is low.
- R13: A flag never reports data or space that is not there, at any clock. After both clocks have idled for eight read cycles, all four flags match the stored level exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| wr_en1 | input | 1 | Primary write enable, active high |
| wr_en2_load | input | 1 | Second write enable or threshold access select; role latched during reset |
| din | input | DW | Write data; the low byte also carries threshold parts |
| rd_en1 | input | 1 | Primary read enable, active high |
| rd_en2 | input | 1 | Secondary read enable, active high |
| out_en | input | 1 | Drives `dout` when high, floats it when low |
| dout | output | DW | Read data or threshold read-back |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| almost_full_n | output | 1 | Low at or above the almost-full level (write domain) |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |
| almost_empty_n | output | 1 | Low at or below the almost-empty level (read domain) |

## Verification
The hardest states to reach are the exact threshold boundaries. Examples are a level equal to a 10-bit almost-empty threshold whose high part is nonzero, and the single word that tips the buffer from one below full to full. The bench reaches them from the ports in three steps. First it loads thresholds such as n = 258 and m = 20 through the data bus. Next it writes exactly the counted number of words, and then lets both clocks idle until the pointer crossing settles before it compares the flags. Threshold read-back is done with words still stored, and the drain that follows shows that none of them was consumed.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

  // Threshold part select; bit 1 picks the threshold, bit 0 picks low/high part.
  typedef enum logic [1:0] {
    OFS_AE_LO = 2'd0,
    OFS_AE_HI = 2'd1,
    OFS_AF_LO = 2'd2,
    OFS_AF_HI = 2'd3
  } ofs_sel_e;

  function automatic ofs_sel_e ofs_sel_next(input ofs_sel_e cur);
    return ofs_sel_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with enable: output holds between reads.
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign bin_out = gray_to_bin(sync_q);
endmodule

// File: rtl/fifo_offset_bank.sv
module fifo_offset_bank
  import fifo_pkg::*;
#(
  parameter int OW  = 10,
  parameter int DEF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_fire,
  input  logic [7:0]    ld_byte,
  input  ofs_sel_e      rb_sel,
  output logic [7:0]    rb_byte,
  output logic [OW-1:0] ae_ofs,
  output logic [OW-1:0] af_ofs
);
  localparam int HW = OW - 8;
  localparam logic [OW-1:0] DEF_V = OW'(DEF);

  ofs_sel_e ld_sel;

  always_ff @(posedge clk) begin
    if (rst) ld_sel <= OFS_AE_LO;
    else if (ld_fire) ld_sel <= ofs_sel_next(ld_sel);
  end

  // One low byte and one high part per threshold: index 0 = almost-empty, 1 = almost-full.
  for (genvar g = 0; g < 2; g++) begin : g_ofs
    localparam logic IDX = (g == 1);
    logic [7:0]    lo_q;
    logic [HW-1:0] hi_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= DEF_V[7:0];
        hi_q <= DEF_V[OW-1:8];
      end else if (ld_fire && (ld_sel[1] == IDX)) begin
        if (!ld_sel[0]) lo_q <= ld_byte;
        else            hi_q <= ld_byte[HW-1:0];
      end
    end
  end

  assign ae_ofs = {g_ofs[0].hi_q, g_ofs[0].lo_q};
  assign af_ofs = {g_ofs[1].hi_q, g_ofs[1].lo_q};

  always_comb begin
    case (rb_sel)
      OFS_AE_LO: rb_byte = g_ofs[0].lo_q;
      OFS_AE_HI: rb_byte = 8'(g_ofs[0].hi_q);
      OFS_AF_LO: rb_byte = g_ofs[1].lo_q;
      default:   rb_byte = 8'(g_ofs[1].hi_q);
    endcase
  end
endmodule

// File: rtl/sfifo_pflag.sv
module sfifo_pflag
  import fifo_pkg::*;
#(
  parameter int DW          = 9,
  parameter int AW          = 10,
  parameter int OFS_DEFAULT = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en1,
  input  logic          wr_en2_load,
  input  logic [DW-1:0] din,
  input  logic          rd_en1,
  input  logic          rd_en2,
  input  logic          out_en,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          almost_full_n,
  output logic          empty_n,
  output logic          almost_empty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  // ---------------- write domain ----------------
  logic [PW-1:0] wr_ptr, wr_gray, rd_ptr_ws, wr_ptr_nx, w_level_nx;
  logic          load_mode_w;
  logic          wr_req, wr_fire, ofs_wr;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic [7:0]    rb_byte;
  ofs_sel_e      rb_sel;

  assign wr_req     = load_mode_w ? (wr_en1 && !wr_en2_load) : (wr_en1 && wr_en2_load);
  assign ofs_wr     = load_mode_w && wr_en1 && wr_en2_load;
  assign wr_fire    = wr_req && full_n;
  assign wr_ptr_nx  = wr_ptr + PW'(wr_fire);
  assign w_level_nx = wr_ptr_nx - rd_ptr_ws;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wr_ptr        <= '0;
      wr_gray       <= '0;
      full_n        <= 1'b1;
      almost_full_n <= 1'b1;
      load_mode_w   <= !wr_en2_load;
    end else begin
      wr_ptr        <= wr_ptr_nx;
      wr_gray       <= wr_ptr_nx ^ (wr_ptr_nx >> 1);
      full_n        <= (int'(w_level_nx) != DEPTH);
      almost_full_n <= (int'(w_level_nx) + int'(af_ofs)) < DEPTH;
    end
  end

  fifo_offset_bank #(.OW(AW), .DEF(OFS_DEFAULT)) u_ofs (
    .clk     (wclk),
    .rst     (rst),
    .ld_fire (ofs_wr),
    .ld_byte (din[7:0]),
    .rb_sel  (rb_sel),
    .rb_byte (rb_byte),
    .ae_ofs  (ae_ofs),
    .af_ofs  (af_ofs)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] rd_ptr, rd_gray, wr_ptr_rs, rd_ptr_nx, r_level_nx;
  logic          load_mode_r;
  logic          rd_both, rb_active, rd_fire, ofs_rd;
  logic          src_ofs;
  logic [7:0]    ofs_q;
  logic [DW-1:0] ram_q;

  assign rd_both    = rd_en1 && rd_en2;
  assign rb_active  = load_mode_r && wr_en2_load;
  assign ofs_rd     = rb_active && rd_both;
  assign rd_fire    = rd_both && !rb_active && empty_n;
  assign rd_ptr_nx  = rd_ptr + PW'(rd_fire);
  assign r_level_nx = wr_ptr_rs - rd_ptr_nx;

  always_ff @(posedge rclk) begin
    if (rst) begin
      rd_ptr         <= '0;
      rd_gray        <= '0;
      empty_n        <= 1'b0;
      almost_empty_n <= 1'b0;
      load_mode_r    <= !wr_en2_load;
      rb_sel         <= OFS_AE_LO;
      src_ofs        <= 1'b0;
      ofs_q          <= '0;
    end else begin
      rd_ptr         <= rd_ptr_nx;
      rd_gray        <= rd_ptr_nx ^ (rd_ptr_nx >> 1);
      empty_n        <= (r_level_nx != '0);
      almost_empty_n <= int'(r_level_nx) > int'(ae_ofs);
      if (ofs_rd) begin
        rb_sel  <= ofs_sel_next(rb_sel);
        ofs_q   <= rb_byte;
        src_ofs <= 1'b1;
      end else if (rd_fire) begin
        src_ofs <= 1'b0;
      end
    end
  end

  // ---------------- pointer crossing ----------------
  fifo_ptr_sync #(.W(PW)) u_r2w (
    .clk (wclk), .rst (rst), .gray_in (rd_gray), .bin_out (rd_ptr_ws)
  );
  fifo_ptr_sync #(.W(PW)) u_w2r (
    .clk (rclk), .rst (rst), .gray_in (wr_gray), .bin_out (wr_ptr_rs)
  );

  // ---------------- storage ----------------
  fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wclk),
    .we    (wr_fire),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (din),
    .rclk  (rclk),
    .re    (rd_fire),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (ram_q)
  );

  assign dout = out_en ? (src_ofs ? DW'(ofs_q) : ram_q) : 'z;
endmodule

// File: rtl/sfifo_pflag_chk.sv
module sfifo_pflag_chk #(
  parameter int AW = 10
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst,
  input logic        full_n,
  input logic        almost_full_n,
  input logic        empty_n,
  input logic        almost_empty_n,
  input logic        wr_en2_load,
  input logic        load_mode_w,
  input logic        load_mode_r,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] rd_ptr,
  input logic [AW:0] wr_gray
);
  // R4: no pointer advance on an edge where the buffer was full
  a_r4_full_blocks_write: assert property (@(posedge wclk) disable iff (rst)
    !full_n |=> $stable(wr_ptr));

  // R5: no pointer advance on an edge where the buffer was empty
  a_r5_empty_blocks_read: assert property (@(posedge rclk) disable iff (rst)
    !empty_n |=> $stable(rd_ptr));

  // R9: threshold loading stores no word
  a_r9_load_no_push: assert property (@(posedge wclk) disable iff (rst)
    (load_mode_w && wr_en2_load) |=> $stable(wr_ptr));

  // R10: threshold read-back consumes no word
  a_r10_readback_no_pop: assert property (@(posedge rclk) disable iff (rst)
    (load_mode_r && wr_en2_load) |=> $stable(rd_ptr));

  // R6: full is never reported without almost-full
  a_r6_full_implies_afull: assert property (@(posedge wclk) disable iff (rst)
    !full_n |-> !almost_full_n);

  // R7: empty is never reported without almost-empty
  a_r7_empty_implies_aempty: assert property (@(posedge rclk) disable iff (rst)
    !empty_n |-> !almost_empty_n);

  // R1: the crossing write pointer changes by at most one bit per edge
  a_r1_gray_one_step: assert property (@(posedge wclk) disable iff (rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

bind sfifo_pflag sfifo_pflag_chk #(.AW(AW)) u_chk (
  .wclk           (wclk),
  .rclk           (rclk),
  .rst            (rst),
  .full_n         (full_n),
  .almost_full_n  (almost_full_n),
  .empty_n        (empty_n),
  .almost_empty_n (almost_empty_n),
  .wr_en2_load    (wr_en2_load),
  .load_mode_w    (load_mode_w),
  .load_mode_r    (load_mode_r),
  .wr_ptr         (wr_ptr),
  .rd_ptr         (rd_ptr),
  .wr_gray        (wr_gray)
);

// File: tb/test_sfifo_pflag.sv
module test_sfifo_pflag;
  localparam int CLK_PERIOD = 20;
  localparam int RD_PERIOD  = 28;
  localparam int DW    = 9;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  logic rst = 1'b1;
  logic wr_en1 = 1'b0, wr_en2_load = 1'b0, rd_en1 = 1'b0, rd_en2 = 1'b0, out_en = 1'b0;
  logic [DW-1:0] din = '0;
  wire  [DW-1:0] dout;
  wire  full_n, almost_full_n, empty_n, almost_empty_n;

  // Write edges fall on even times, read edges on odd times: never simultaneous.
  initial forever #(CLK_PERIOD / 2) wclk = ~wclk;
  initial begin
    #3;
    forever #(RD_PERIOD / 2) rclk = ~rclk;
  end

  sfifo_pflag #(.DW(DW), .AW(AW), .OFS_DEFAULT(7)) i_sfifo_pflag (
    .wclk (wclk), .rclk (rclk), .rst (rst),
    .wr_en1 (wr_en1), .wr_en2_load (wr_en2_load), .din (din),
    .rd_en1 (rd_en1), .rd_en2 (rd_en2), .out_en (out_en), .dout (dout),
    .full_n (full_n), .almost_full_n (almost_full_n),
    .empty_n (empty_n), .almost_empty_n (almost_empty_n)
  );

  // ---------------- reference model ----------------
  int q[$];
  int n_chk = 0, n_fail = 0;
  int cur_ae = 7, cur_af = 7;
  int w_val = 0, wdat = 0, exp_rd = 0, last_rd = 0;
  bit w_commit = 0, r_commit = 0, rd_pending = 0, load_mode = 0, run_chk = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge wclk) if (w_commit) q.push_back(w_val);
  always @(posedge rclk) if (r_commit) begin
    exp_rd = q.pop_front();
    rd_pending = 1;
  end

  // R13: per-clock conservative flag checks
  always @(negedge wclk) if (run_chk) begin
    chk("R13/R4 full flag released early", 32'(full_n && q.size() >= DEPTH), 0);
    chk("R13/R6 almost-full released early", 32'(almost_full_n && q.size() >= DEPTH - cur_af), 0);
  end
  always @(negedge rclk) if (run_chk) begin
    chk("R13/R5 empty flag released early", 32'(empty_n && q.size() == 0), 0);
    chk("R13/R7 almost-empty released early", 32'(almost_empty_n && q.size() <= cur_ae), 0);
  end

  task automatic check_flags(input string tag);
    repeat (8) @(posedge rclk);
    @(negedge wclk);
    chk({tag, " R4 full_n"},         full_n,         32'(q.size() != DEPTH));
    chk({tag, " R6 almost_full_n"},  almost_full_n,  32'(q.size() < DEPTH - cur_af));
    chk({tag, " R5 empty_n"},        empty_n,        32'(q.size() != 0));
    chk({tag, " R7 almost_empty_n"}, almost_empty_n, 32'(q.size() > cur_ae));
  endtask

  task automatic cmp_pending();
    if (rd_pending) begin
      chk("R1 read order", 32'(dout), 32'(exp_rd));
      last_rd = exp_rd;
      rd_pending = 0;
    end
  endtask

  task automatic wr_burst(input int n, input bit en2);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en1 = 1'b1;
      din = DW'(wdat);
      wr_en2_load = load_mode ? 1'b0 : en2;
      w_val = wdat;
      w_commit = full_n && (load_mode || en2);
      if (w_commit) wdat = (wdat + 1) % 512;
    end
    @(negedge wclk);
    wr_en1 = 1'b0;
    w_commit = 0;
    wr_en2_load = !load_mode;
  endtask

  task automatic rd_burst(input int n, input bit en2);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      cmp_pending();
      rd_en1 = 1'b1;
      rd_en2 = en2;
      r_commit = en2 && empty_n && !(load_mode && wr_en2_load);
    end
    @(negedge rclk);
    cmp_pending();
    rd_en1 = 1'b0;
    rd_en2 = 1'b0;
    r_commit = 0;
  endtask

  task automatic ofs_load(input logic [7:0] b);
    @(negedge wclk);
    wr_en1 = 1'b1; wr_en2_load = 1'b1; din = DW'(b);
    @(negedge wclk);
    wr_en1 = 1'b0; wr_en2_load = 1'b0;
  endtask

  task automatic ofs_read(input int exp, input string tag);
    @(negedge rclk);
    wr_en2_load = 1'b1; rd_en1 = 1'b1; rd_en2 = 1'b1;
    @(negedge rclk);
    rd_en1 = 1'b0; rd_en2 = 1'b0; wr_en2_load = 1'b0;
    chk(tag, 32'(dout), 32'(exp));
  endtask

  task automatic do_reset(input bit pin);
    run_chk = 0;
    rst = 1'b1;
    wr_en1 = 1'b0; rd_en1 = 1'b0; rd_en2 = 1'b0;
    wr_en2_load = pin;
    w_commit = 0; r_commit = 0;
    repeat (4) @(negedge rclk);
    rst = 1'b0;
    q.delete();
    rd_pending = 0;
    load_mode = !pin;
    cur_ae = 7; cur_af = 7;
    run_chk = 1;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // ---- load mode (R11) ----
    do_reset(1'b0);
    @(negedge wclk);
    chk("R12 dout floats at reset", 32'(dout === 9'bz), 1);
    chk("reset R5 empty_n", empty_n, 0);
    chk("reset R7 almost_empty_n", almost_empty_n, 0);
    chk("reset R4 full_n", full_n, 1);
    chk("reset R6 almost_full_n", almost_full_n, 1);
    out_en = 1'b1;

    ofs_read(7, "R8/R10 default n low");
    ofs_read(0, "R8/R10 default n high");
    ofs_read(7, "R8/R10 default m low");
    ofs_read(0, "R8/R10 default m high");

    ofs_load(8'h02); ofs_load(8'hFD); ofs_load(8'd20); ofs_load(8'h00);
    cur_ae = 258; cur_af = 20;
    check_flags("R9 load stores no word");
    ofs_read(2,  "R9/R10 n low");
    ofs_read(1,  "R9/R10 n high upper bits zero");
    ofs_read(20, "R9/R10 m low");
    ofs_read(0,  "R9/R10 m high");

    wr_burst(258, 1'b1);
    check_flags("R11/R7 level equals n");
    wr_burst(1, 1'b1);
    check_flags("R7 level n+1");
    ofs_read(2, "R10 read-back with words stored");
    rd_burst(259, 1'b1);
    check_flags("R10 nothing consumed by read-back");

    wr_burst(1003, 1'b1);
    check_flags("R6 one below almost-full");
    wr_burst(1, 1'b1);
    check_flags("R6 at almost-full");
    wr_burst(20, 1'b1);
    check_flags("R4 full");
    wr_burst(5, 1'b1);
    check_flags("R4 writes while full dropped");
    rd_burst(DEPTH, 1'b1);
    check_flags("R4 drained");

    // ---- second-enable mode (R11) ----
    do_reset(1'b1);
    wr_burst(6, 1'b0);
    check_flags("R2/R11 single enable stores nothing");
    wr_burst(7, 1'b1);
    check_flags("R8/R7 default n boundary");
    wr_burst(1, 1'b1);
    check_flags("R7 above default n");
    rd_burst(4, 1'b0);
    check_flags("R3 single read enable removes nothing");
    rd_burst(8, 1'b1);
    rd_burst(3, 1'b1);
    chk("R5 dout holds on empty reads", 32'(dout), 32'(last_rd));
    check_flags("R5 empty after reads");
    wr_burst(1016, 1'b1);
    check_flags("R8/R6 below default m");
    wr_burst(1, 1'b1);
    check_flags("R8/R6 at default m");
    rd_burst(1017, 1'b1);

    fork
      wr_burst(600, 1'b1);
      rd_burst(700, 1'b1);
    join
    check_flags("R1 concurrent traffic");
    rd_burst(q.size() + 2, 1'b1);
    check_flags("R1 drained after concurrent traffic");

    out_en = 1'b0;
    @(negedge wclk);
    chk("R12 dout floats when disabled", 32'(dout === 9'bz), 1);

    run_chk = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule